// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This unit collects the interrupt conditions of an enhanced 16550-style serial port. It masks them with a one-byte enable register and reports only the most urgent one. The result is a six-bit identification code, together with a single interrupt request line. Seven priority levels are served:

- the four classic sources: line status, receive timeout, receive ready and transmit ready;
- modem status;
- two enhanced sources: reception of an Xoff or special character, and a change on the CTS or RTS pins.

The enhanced sources, and a sleep request, are gated by an enhanced-features bit supplied from outside.

Event-type conditions are held in sticky latches inside the unit. Each latch is released by its own clear strobe, such as a line-status read or a modem-status read. The receive-ready and receive-timeout conditions are levels that come straight from the receiver. Transmit ready is armed by a rising edge of the transmitter-empty flag. It is disarmed by a status-register read that returns it, or by a write to the transmit holding register. The status read data carries the code in bits [5:0] and passes an external FIFO-state field into bits [7:6].

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the status code is 000001, the interrupt line is low, the sleep request is low and the enable register is zero.
- R2: A write to the enable register stores the byte. Bit 0 enables both receive sources, bit 1 enables transmit ready, bit 2 enables line status and bit 3 enables modem status; a cleared bit hides its source from the code.
- R3: With several sources active and enabled, the code is that of the highest of them. The order from highest down is line status 000110, receive timeout 001100, receive ready 000100, transmit ready 000010, modem status 000000, Xoff/special 010000, CTS/RTS change 100000.
- R4: With no enabled active source the code is 000001. The interrupt line equals the inverse of code bit 0, and it drops in the same cycle that the last pending source clears.
- R5: A rising edge of the transmitter-empty flag arms transmit ready. The source is disarmed by a status read while its code is shown, or by a transmit holding register write. A flag that stays high does not re-arm it.
- R6: Line-status, modem-status, Xoff and CTS/RTS conditions stay latched until their own clear strobe. A status read, or any other strobe, leaves them set.
- R7: Receive ready and receive timeout follow their input levels in the same cycle, with no latching.
- R8: Enable bits 5 (Xoff), 6 (RTS change) and 7 (CTS change) act only while the enhanced bit is 1. Clearing the enhanced bit hides those sources at once but keeps their latches, which reappear when the bit returns.
- R9: Status read data bits [7:6] equal the external FIFO-state input.
- R10: When a latch's set event and its clear strobe arrive in the same cycle, the latch ends up set.
- R11: The sleep request output equals enable bit 4 AND the enhanced bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| enh_en | input | 1 | Enhanced-features unlock bit |
| rx_ready | input | 1 | Receive data ready level |
| rx_timeout | input | 1 | Receive timeout level |
| tx_empty | input | 1 | Transmit holding register empty flag |
| thr_write | input | 1 | Transmit holding register write strobe |
| line_evt | input | 1 | Line status error event |
| line_rd | input | 1 | Line status register read strobe |
| modem_evt | input | 1 | Modem status change event |
| modem_rd | input | 1 | Modem status register read strobe |
| xoff_evt | input | 1 | Xoff or special character received |
| xoff_clr | input | 1 | Xoff condition clear strobe |
| rts_evt | input | 1 | RTS output change event |
| cts_evt | input | 1 | CTS input change event |
| flow_clr | input | 1 | CTS/RTS change clear strobe |
| isr_rd | input | 1 | Status register read strobe |
| fifo_stat | input | 2 | FIFO-state bits passed to read data [7:6] |
| isr_rdata | output | 8 | Status read data |
| irq | output | 1 | Interrupt request |
| sleep_req | output | 1 | Sleep mode request |

## Verification
The bench builds the unit with its default parameters: an 8-bit enable register and a 2-bit FIFO-state field. This is the only width at which the code table and the split between the lower and upper enable nibbles are defined. With these values, every one of the seven levels, the masking effect of each enable bit and the enhanced-bit gating can be reached from the ports. Directed sequences cover the priority ladder, same-cycle set/clear races and transmit edge re-arming. A long random phase then compares every cycle against a behavioural model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_LVL = 7;
  localparam int CODE_W  = 6;
  localparam logic [CODE_W-1:0] CODE_IDLE = 6'b000001;

  typedef enum logic [2:0] {
    LVL_LINE  = 3'd0,
    LVL_RXTO  = 3'd1,
    LVL_RXRDY = 3'd2,
    LVL_TXRDY = 3'd3,
    LVL_MODEM = 3'd4,
    LVL_XOFF  = 3'd5,
    LVL_FLOW  = 3'd6
  } lvl_e;

  function automatic logic [CODE_W-1:0] lvl_code(input int idx);
    case (idx)
      0:       return 6'b000110;
      1:       return 6'b001100;
      2:       return 6'b000100;
      3:       return 6'b000010;
      4:       return 6'b000000;
      5:       return 6'b010000;
      6:       return 6'b100000;
      default: return CODE_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/uirq_enable.sv
module uirq_enable #(
  parameter int IER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IER_W-1:0]   wdata,
  input  logic               enh_en,
  output logic [IER_W/2-1:0] base_en,
  output logic [IER_W/2-1:0] ext_en
);
  localparam int HALF = IER_W / 2;

  logic [IER_W-1:0] ier_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ier_q <= '0;
    else if (we) ier_q <= wdata;
  end

  assign base_en = ier_q[HALF-1:0];
  assign ext_en  = enh_en ? ier_q[IER_W-1:HALF] : '0;
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (set_evt) q <= 1'b1;
    else if (clr_evt) q <= 1'b0;
  end
endmodule

// File: rtl/uirq_tx_arm.sv
module uirq_tx_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic thr_write,
  input  logic isr_rd,
  input  logic reported,
  output logic pend,
  output logic arm_evt
);
  logic empty_q;
  logic clr_evt;

  assign arm_evt = tx_empty & ~empty_q;
  assign clr_evt = thr_write | (isr_rd & reported);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      pend    <= 1'b0;
    end else begin
      empty_q <= tx_empty;
      if (arm_evt)      pend <= 1'b1;
      else if (clr_evt) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_LVL-1:0] act,
  output logic [CODE_W-1:0]  code,
  output logic [NUM_LVL-1:0] sel
);
  always_comb begin
    code = CODE_IDLE;
    sel  = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (act[i]) begin
        code   = lvl_code(i);
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int IER_W  = 8,
  parameter int FIFO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ier_we,
  input  logic [IER_W-1:0]  ier_wdata,
  input  logic              enh_en,
  input  logic              rx_ready,
  input  logic              rx_timeout,
  input  logic              tx_empty,
  input  logic              thr_write,
  input  logic              line_evt,
  input  logic              line_rd,
  input  logic              modem_evt,
  input  logic              modem_rd,
  input  logic              xoff_evt,
  input  logic              xoff_clr,
  input  logic              rts_evt,
  input  logic              cts_evt,
  input  logic              flow_clr,
  input  logic              isr_rd,
  input  logic [FIFO_W-1:0] fifo_stat,
  output logic [CODE_W+FIFO_W-1:0] isr_rdata,
  output logic              irq,
  output logic              sleep_req
);
  localparam int HALF     = IER_W / 2;
  localparam int N_STICKY = 5;
  localparam int S_LINE = 0, S_MODEM = 1, S_XOFF = 2, S_RTS = 3, S_CTS = 4;

  logic [HALF-1:0]     base_en, ext_en;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [NUM_LVL-1:0]  act, sel;
  logic [CODE_W-1:0]   code;
  logic                thre_q, tx_arm_evt, lsr_q;

  uirq_enable #(.IER_W(IER_W)) u_en (
    .clk(clk), .rst_n(rst_n), .we(ier_we), .wdata(ier_wdata),
    .enh_en(enh_en), .base_en(base_en), .ext_en(ext_en)
  );

  assign st_set = {cts_evt, rts_evt, xoff_evt, modem_evt, line_evt};
  assign st_clr = {flow_clr, flow_clr, xoff_clr, modem_rd, line_rd};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    uirq_sticky u_lat (
      .clk(clk), .rst_n(rst_n), .set_evt(st_set[g]),
      .clr_evt(st_clr[g]), .q(st_q[g])
    );
  end

  assign lsr_q = st_q[S_LINE];

  uirq_tx_arm u_tx (
    .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .thr_write(thr_write),
    .isr_rd(isr_rd), .reported(sel[LVL_TXRDY]), .pend(thre_q),
    .arm_evt(tx_arm_evt)
  );

  always_comb begin
    act            = '0;
    act[LVL_LINE]  = st_q[S_LINE]  & base_en[2];
    act[LVL_RXTO]  = rx_timeout    & base_en[0];
    act[LVL_RXRDY] = rx_ready      & base_en[0];
    act[LVL_TXRDY] = thre_q        & base_en[1];
    act[LVL_MODEM] = st_q[S_MODEM] & base_en[3];
    act[LVL_XOFF]  = st_q[S_XOFF]  & ext_en[1];
    act[LVL_FLOW]  = (st_q[S_RTS] & ext_en[2]) | (st_q[S_CTS] & ext_en[3]);
  end

  uirq_prio u_prio (.act(act), .code(code), .sel(sel));

  assign isr_rdata = {fifo_stat, code};
  assign irq       = ~code[0];
  assign sleep_req = ext_en[0];
endmodule

// File: rtl/uirq_checks.sv
module uirq_checks
  import uart_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         isr_rdata,
  input logic               irq,
  input logic               enh_en,
  input logic               sleep_req,
  input logic [NUM_LVL-1:0] sel,
  input logic               lsr_q,
  input logic               line_rd,
  input logic               thre_q,
  input logic               thr_write,
  input logic               tx_arm_evt
);
  // R4
  irq_vs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !isr_rdata[0]);
  // R3
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // R6
  line_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_q && !line_rd) |=> lsr_q);
  // R8
  enh_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |-> (isr_rdata[5:0] != 6'b010000 && isr_rdata[5:0] != 6'b100000 && !sleep_req));
  // R5
  thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_write && !tx_arm_evt) |=> !thre_q);
endmodule

bind uart_irq_ident uirq_checks u_chk (
  .clk(clk), .rst_n(rst_n), .isr_rdata(isr_rdata), .irq(irq),
  .enh_en(enh_en), .sleep_req(sleep_req), .sel(sel), .lsr_q(lsr_q),
  .line_rd(line_rd), .thre_q(thre_q), .thr_write(thr_write),
  .tx_arm_evt(tx_arm_evt)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_we = 0;
  logic [7:0] ier_wdata = 0;
  logic enh_en = 0, rx_ready = 0, rx_timeout = 0, tx_empty = 0, thr_write = 0;
  logic line_evt = 0, line_rd = 0, modem_evt = 0, modem_rd = 0;
  logic xoff_evt = 0, xoff_clr = 0, rts_evt = 0, cts_evt = 0, flow_clr = 0;
  logic isr_rd = 0;
  logic [1:0] fifo_stat = 0;
  logic [7:0] isr_rdata;
  logic irq, sleep_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
    .enh_en(enh_en), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
    .tx_empty(tx_empty), .thr_write(thr_write), .line_evt(line_evt),
    .line_rd(line_rd), .modem_evt(modem_evt), .modem_rd(modem_rd),
    .xoff_evt(xoff_evt), .xoff_clr(xoff_clr), .rts_evt(rts_evt),
    .cts_evt(cts_evt), .flow_clr(flow_clr), .isr_rd(isr_rd),
    .fifo_stat(fifo_stat), .isr_rdata(isr_rdata), .irq(irq),
    .sleep_req(sleep_req)
  );

  // behavioural reference state
  bit [7:0] m_ier = 0;
  bit m_line = 0, m_modem = 0, m_xoff = 0, m_rts = 0, m_cts = 0;
  bit m_thre = 0, m_prev_empty = 0;

  function automatic bit [5:0] ref_code();
    bit hi;
    hi = enh_en;
    if (m_line && m_ier[2])               return 6'b000110;
    if (rx_timeout && m_ier[0])           return 6'b001100;
    if (rx_ready && m_ier[0])             return 6'b000100;
    if (m_thre && m_ier[1])               return 6'b000010;
    if (m_modem && m_ier[3])              return 6'b000000;
    if (hi && m_xoff && m_ier[5])         return 6'b010000;
    if (hi && ((m_rts && m_ier[6]) || (m_cts && m_ier[7]))) return 6'b100000;
    return 6'b000001;
  endfunction

  function automatic bit upd(bit cur, bit s, bit c);
    if (s) return 1'b1;
    if (c) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ier = 0; m_line = 0; m_modem = 0; m_xoff = 0; m_rts = 0; m_cts = 0;
      m_thre = 0; m_prev_empty = 0;
    end else begin
      bit shown_tx;
      shown_tx = (ref_code() == 6'b000010);
      m_thre  = upd(m_thre, tx_empty && !m_prev_empty, thr_write || (isr_rd && shown_tx));
      m_prev_empty = tx_empty;
      m_line  = upd(m_line, line_evt, line_rd);
      m_modem = upd(m_modem, modem_evt, modem_rd);
      m_xoff  = upd(m_xoff, xoff_evt, xoff_clr);
      m_rts   = upd(m_rts, rts_evt, flow_clr);
      m_cts   = upd(m_cts, cts_evt, flow_clr);
      if (ier_we) m_ier = ier_wdata;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit [7:0] exp_rd;
      exp_rd = {fifo_stat, ref_code()};
      checks++;
      if (isr_rdata !== exp_rd || irq !== !exp_rd[0] || sleep_req !== (enh_en & m_ier[4])) begin
        errors++;
        $display("FAIL R3/R4/R11 model: rdata=%b irq=%b sleep=%b expected rdata=%b irq=%b sleep=%b",
                 isr_rdata, irq, sleep_req, exp_rd, !exp_rd[0], enh_en & m_ier[4]);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wdata = v; ier_we = 1; cyc(); ier_we = 0; #1;
  endtask

  task automatic code_is(input string tag, input logic [5:0] exp);
    chk(tag, {2'b00, isr_rdata[5:0]}, {2'b00, exp});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1; #1;
    code_is("R1 reset code", 6'b000001);
    chk("R1 reset irq", {7'd0, irq}, 8'd0);
    chk("R1 reset sleep", {7'd0, sleep_req}, 8'd0);
    rx_ready = 1; #1;
    code_is("R1 enable zero masks rx", 6'b000001);
    rx_ready = 0;

    wr_ier(8'h0F);
    rx_ready = 1; #1;
    code_is("R7 rx ready level", 6'b000100);
    rx_timeout = 1; #1;
    code_is("R3 timeout over ready", 6'b001100);
    line_evt = 1; cyc(); line_evt = 0; #1;
    code_is("R3 line highest", 6'b000110);
    rx_ready = 0; rx_timeout = 0; #1;
    code_is("R6 line stays latched", 6'b000110);
    isr_rd = 1; cyc(); isr_rd = 0; #1;
    code_is("R6 status read keeps line", 6'b000110);
    line_rd = 1; cyc(); line_rd = 0; #1;
    code_is("R4 idle after line read", 6'b000001);
    chk("R4 irq drops same cycle", {7'd0, irq}, 8'd0);

    modem_evt = 1; cyc(); modem_evt = 0; #1;
    code_is("R3 modem level", 6'b000000);
    chk("R4 irq with modem", {7'd0, irq}, 8'd1);
    tx_empty = 1; cyc(); #1;
    code_is("R5 tx armed on edge", 6'b000010);
    isr_rd = 1; cyc(); isr_rd = 0; #1;
    code_is("R5 status read clears tx", 6'b000000);
    cyc(); cyc(); #1;
    code_is("R5 steady empty no rearm", 6'b000000);
    modem_rd = 1; cyc(); modem_rd = 0; #1;
    code_is("R6 modem read clears", 6'b000001);
    tx_empty = 0; cyc(); tx_empty = 1; cyc(); #1;
    code_is("R5 rearm on new edge", 6'b000010);
    thr_write = 1; cyc(); thr_write = 0; #1;
    code_is("R5 holding write clears tx", 6'b000001);

    line_evt = 1; line_rd = 1; cyc(); line_evt = 0; line_rd = 0; #1;
    code_is("R10 set beats clear", 6'b000110);
    line_rd = 1; cyc(); line_rd = 0; #1;
    code_is("R10 later clear", 6'b000001);

    wr_ier(8'hFF);
    xoff_evt = 1; cyc(); xoff_evt = 0; #1;
    code_is("R8 xoff hidden without enhanced", 6'b000001);
    chk("R11 sleep gated", {7'd0, sleep_req}, 8'd0);
    enh_en = 1; #1;
    code_is("R8 xoff appears", 6'b010000);
    chk("R11 sleep on", {7'd0, sleep_req}, 8'd1);
    cts_evt = 1; cyc(); cts_evt = 0; #1;
    code_is("R3 xoff over flow", 6'b010000);
    xoff_clr = 1; cyc(); xoff_clr = 0; #1;
    code_is("R3 flow level", 6'b100000);
    enh_en = 0; #1;
    code_is("R8 flow masked", 6'b000001);
    enh_en = 1; #1;
    code_is("R8 latch kept", 6'b100000);
    flow_clr = 1; cyc(); flow_clr = 0; #1;
    code_is("R6 flow clear", 6'b000001);
    wr_ier(8'hBF);
    rts_evt = 1; cyc(); rts_evt = 0; #1;
    code_is("R8 rts bit6 off", 6'b000001);
    wr_ier(8'hFF);
    code_is("R8 rts enabled later", 6'b100000);
    flow_clr = 1; cyc(); flow_clr = 0;

    wr_ier(8'h08);
    modem_evt = 1; cyc(); modem_evt = 0; #1;
    code_is("R2 modem bit3", 6'b000000);
    rx_ready = 1; #1;
    code_is("R2 rx masked by bit0", 6'b000000);
    wr_ier(8'h01);
    code_is("R2 rx bit0", 6'b000100);
    rx_ready = 0; #1;
    code_is("R2 modem masked", 6'b000001);
    modem_rd = 1; cyc(); modem_rd = 0;

    fifo_stat = 2'b10; #1;
    chk("R9 fifo field", {6'd0, isr_rdata[7:6]}, 8'd2);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      ier_we     = ($urandom_range(0, 15) == 0);
      ier_wdata  = 8'($urandom);
      enh_en     = ($urandom_range(0, 7) != 0);
      rx_ready   = ($urandom_range(0, 3) == 0);
      rx_timeout = ($urandom_range(0, 7) == 0);
      tx_empty   = ($urandom_range(0, 2) != 0);
      thr_write  = ($urandom_range(0, 9) == 0);
      line_evt   = ($urandom_range(0, 11) == 0);
      line_rd    = ($urandom_range(0, 5) == 0);
      modem_evt  = ($urandom_range(0, 11) == 0);
      modem_rd   = ($urandom_range(0, 5) == 0);
      xoff_evt   = ($urandom_range(0, 11) == 0);
      xoff_clr   = ($urandom_range(0, 5) == 0);
      rts_evt    = ($urandom_range(0, 11) == 0);
      cts_evt    = ($urandom_range(0, 11) == 0);
      flow_clr   = ($urandom_range(0, 5) == 0);
      isr_rd     = ($urandom_range(0, 3) == 0);
      fifo_stat  = 2'($urandom);
    end
    @(negedge clk);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule